// File: doc/BRIEF.md
# Parallel Sampling-Converter Read Sequencer

This block runs on the system clock and drives an external 12-bit parallel-output sampling converter. It divides the system clock down to make the converter clock. An interval timer raises a sample request every `sample_period + 1` enabled cycles. When the sequencer is idle, a request sends out an active-low start strobe. The sequencer then waits until the converter's done line has first dropped and then risen again. After that it runs a select/read bus cycle, takes the data word at a fixed point inside the read strobe, and reports it as a one-cycle valid pulse with the data held beside it.

Every strobe width, access delay and bus-release gap is given in nanoseconds and converted to whole system cycles, rounding up. A sleep request drops the power line and keeps read high. When the request is released, power comes back on and one converter clock period passes. The sequencer then runs one throw-away conversion whose data is never presented. Requests that arrive while the sequencer is busy or asleep are not queued; they are counted as dropped. If the done line does not return high within a bounded number of converter clocks after a start, a sticky timeout flag is set.

Top module: `adc_read_ctrl`

## Requirements
- R1: While reset is low and just after it: start, select and read are high, power is high, valid is low, the timeout flag is low and the dropped count is 0.
- R2: The converter clock is high for 32 system cycles and then low for 32, with the default 250 ns half period at 8 ns per cycle.
- R3: Only in the idle state does a sample request (one per `sample_period + 1` enabled cycles) start a conversion. The start strobe stays low for exactly 7 cycles (50 ns rounded up) before it rises.
- R4: Select falls only after the done line has been seen low since the start and is high again.
- R5: Read falls one cycle after select and stays low for 14 cycles. The data word is captured on the 13th edge of read low (100 ns rounded up), never earlier.
- R6: Select rises one cycle after read rises. The next start strobe comes at least 12 cycles (90 ns rounded up) after read rises.
- R7: Each captured sample appears as a valid pulse lasting one cycle, with the data value that was on the bus at the capture edge.
- R8: A sample request that finds the sequencer anywhere other than idle, or idle with sleep requested, increments the dropped count by one.
- R9: While asleep, power is low, read and start stay high, and no conversion starts.
- R10: On wake, power rises first. The wake start strobe falls at least 64 cycles (one converter clock period) later, and its data never raises valid.
- R11: If the done line has not completed its low-then-high sequence within 40 converter clocks (2560 cycles) after the start edge, the timeout flag rises and stays high. No read cycle follows that start.
- R12: If a sample request and a sleep request fall in the same idle cycle, sleep wins and the request is counted as dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Runs the sample interval timer |
| sample_period | input | 16 | Request interval minus one, in system cycles |
| sleep_req | input | 1 | Requests power-save |
| cvt_done | input | 1 | Converter done line, low while converting (asynchronous) |
| cvt_data | input | 12 | Converter parallel data bus |
| conv_clk | output | 1 | Divided converter clock |
| cvt_start_n | output | 1 | Active-low convert-start strobe |
| sel_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| pwr_on | output | 1 | Low puts the converter in power-save |
| samp_valid | output | 1 | One-cycle captured-sample pulse |
| samp_data | output | 12 | Last captured sample |
| tmo_err | output | 1 | Sticky conversion timeout flag |
| drop_count | output | 16 | Count of dropped sample requests |

## Verification
A sample request from the interval timer and a sleep request can land on the same idle cycle. The bench provokes this by predicting the cycle of the next request from its own count of enabled cycles and raising sleep on exactly that cycle. The result is judged by whether power drops with no start strobe, and by whether the dropped count still equals the bench's count of requests minus its count of non-wake starts. The same count identity is checked after a run in which the request interval is shorter than a conversion, so that requests collide with busy cycles again and again.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CNV_LO,
      ST_WAIT_LO,
      ST_WAIT_HI,
      ST_SEL_ON,
      ST_RD_LO,
      ST_RD_HI,
      ST_FLOAT,
      ST_SLEEP,
      ST_WAKE
   } rd_state_e;

   // whole system cycles covering a time in ns, rounded up
   function automatic int ns_to_cyc(input int ns, input int sys_ps);
      return (ns * 1000 + sys_ps - 1) / sys_ps;
   endfunction

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/conv_clk_gen.sv
module conv_clk_gen #(
   parameter int HALF_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic clk_o
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad
         $error("conv_clk_gen: HALF_CYC must be at least 1");
      end
      if (HALF_CYC == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clk_o <= 1'b0;
            else        clk_o <= ~clk_o;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               clk_o <= 1'b0;
            end else if (cnt == CW'(HALF_CYC - 1)) begin
               cnt   <= '0;
               clk_o <= ~clk_o;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         // R2
         half_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(clk_o) |=> $stable(clk_o));
      end
   endgenerate
endmodule

// File: rtl/samp_timer.sv
module samp_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   logic [PERIOD_W-1:0] cnt;

   generate
      if (PERIOD_W < 2) begin : g_bad
         $error("samp_timer: PERIOD_W must be at least 2");
      end
   endgenerate

   assign tick = en && (cnt == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!en)   cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && period != '0 && $stable(period)) |=> !tick);
endmodule

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("sync_chain: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= 1'b1;
            else        pipe[i] <= (i == 0) ? d : pipe[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rd_seq.sv
module rd_seq
   import adc_rd_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int DROP_W   = 16,
   parameter int CNV_CYC  = 7,
   parameter int RDL_CYC  = 14,
   parameter int ACC_CYC  = 13,
   parameter int FLT_CYC  = 12,
   parameter int WAKE_CYC = 64,
   parameter int TMO_CYC  = 2560
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              sleep_req,
   input  logic              done_s,
   input  logic [DATA_W-1:0] bus_d,
   output logic              cvt_start_n,
   output logic              sel_n,
   output logic              rd_n,
   output logic              pwr_on,
   output logic              samp_valid,
   output logic [DATA_W-1:0] samp_data,
   output logic              tmo_err,
   output logic [DROP_W-1:0] drop_count
);
   localparam int CNT_MAX = max_of4(CNV_CYC, RDL_CYC, FLT_CYC, WAKE_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int TMO_W   = $clog2(TMO_CYC + 1);

   generate
      if (RDL_CYC < ACC_CYC || ACC_CYC < 1) begin : g_bad_rd
         $error("rd_seq: read strobe shorter than access time");
      end
      if (CNV_CYC < 1 || FLT_CYC < 1 || WAKE_CYC < 1) begin : g_bad_cyc
         $error("rd_seq: cycle limits must be at least 1");
      end
   endgenerate

   rd_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [TMO_W-1:0] tmo;
   logic             dummy;
   logic             take;

   assign take = (state == ST_IDLE) && !sleep_req;

   assign cvt_start_n = (state != ST_CNV_LO);
   assign sel_n       = !(state inside {ST_SEL_ON, ST_RD_LO, ST_RD_HI});
   assign rd_n        = (state != ST_RD_LO);
   assign pwr_on      = (state != ST_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         tmo        <= '0;
         dummy      <= 1'b0;
         tmo_err    <= 1'b0;
         samp_valid <= 1'b0;
         samp_data  <= '0;
         drop_count <= '0;
      end else begin
         samp_valid <= 1'b0;
         if (tick && !take) drop_count <= drop_count + 1'b1;
         case (state)
            ST_IDLE: begin
               if (sleep_req) state <= ST_SLEEP;
               else if (tick) begin
                  state <= ST_CNV_LO;
                  cnt   <= '0;
               end
            end
            ST_CNV_LO: begin
               if (cnt == CNT_W'(CNV_CYC - 1)) begin
                  state <= ST_WAIT_LO;
                  tmo   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            ST_WAIT_LO, ST_WAIT_HI: begin
               if (tmo == TMO_W'(TMO_CYC - 1)) begin
                  tmo_err <= 1'b1;
                  dummy   <= 1'b0;
                  state   <= ST_IDLE;
               end else begin
                  tmo <= tmo + 1'b1;
                  if (state == ST_WAIT_LO && !done_s) state <= ST_WAIT_HI;
                  if (state == ST_WAIT_HI &&  done_s) state <= ST_SEL_ON;
               end
            end
            ST_SEL_ON: begin
               state <= ST_RD_LO;
               cnt   <= '0;
            end
            ST_RD_LO: begin
               if (cnt == CNT_W'(ACC_CYC - 1) && !dummy) begin
                  samp_valid <= 1'b1;
                  samp_data  <= bus_d;
               end
               if (cnt == CNT_W'(RDL_CYC - 1)) state <= ST_RD_HI;
               else cnt <= cnt + 1'b1;
            end
            ST_RD_HI: begin
               state <= ST_FLOAT;
               cnt   <= '0;
            end
            ST_FLOAT: begin
               if (cnt == CNT_W'(FLT_CYC - 1)) begin
                  state <= ST_IDLE;
                  dummy <= 1'b0;
               end else cnt <= cnt + 1'b1;
            end
            ST_SLEEP: begin
               if (!sleep_req) begin
                  state <= ST_WAKE;
                  cnt   <= '0;
               end
            end
            ST_WAKE: begin
               if (cnt == CNT_W'(WAKE_CYC - 1)) begin
                  state <= ST_CNV_LO;
                  cnt   <= '0;
                  dummy <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5
   rd_under_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !sel_n);

   // R4
   sel_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> $past(done_s));

   // R6
   sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |=> $rose(sel_n));

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      samp_valid |=> !samp_valid);

   // R9
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> (rd_n && cvt_start_n && sel_n));

   // R10
   wake_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on) |-> cvt_start_n);

   // R11
   tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |=> tmo_err);
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
   import adc_rd_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int PERIOD_W      = 16,
   parameter int DROP_W        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int SYS_PS        = 8000,
   parameter int CNV_LOW_NS    = 50,
   parameter int RD_LOW_NS     = 110,
   parameter int ACCESS_NS     = 100,
   parameter int FLOAT_NS      = 90,
   parameter int CCLK_HALF_NS  = 250,
   parameter int TMO_CCLKS     = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] sample_period,
   input  logic                sleep_req,
   input  logic                cvt_done,
   input  logic [DATA_W-1:0]   cvt_data,
   output logic                conv_clk,
   output logic                cvt_start_n,
   output logic                sel_n,
   output logic                rd_n,
   output logic                pwr_on,
   output logic                samp_valid,
   output logic [DATA_W-1:0]   samp_data,
   output logic                tmo_err,
   output logic [DROP_W-1:0]   drop_count
);
   localparam int HALF_CYC = ns_to_cyc(CCLK_HALF_NS, SYS_PS);
   localparam int CCLK_CYC = 2 * HALF_CYC;
   localparam int CNV_CYC  = ns_to_cyc(CNV_LOW_NS, SYS_PS);
   localparam int RDL_CYC  = ns_to_cyc(RD_LOW_NS, SYS_PS);
   localparam int ACC_CYC  = ns_to_cyc(ACCESS_NS, SYS_PS);
   localparam int FLT_CYC  = ns_to_cyc(FLOAT_NS, SYS_PS);
   localparam int TMO_CYC  = TMO_CCLKS * CCLK_CYC;

   generate
      if (SYS_PS < 1 || TMO_CCLKS < 1) begin : g_bad
         $error("adc_read_ctrl: bad clock or timeout parameter");
      end
   endgenerate

   logic tick;
   logic done_s;

   conv_clk_gen #(.HALF_CYC(HALF_CYC)) u_cclk (
      .clk(clk), .rst_n(rst_n), .clk_o(conv_clk));

   samp_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .en(enable), .period(sample_period), .tick(tick));

   sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cvt_done), .q(done_s));

   rd_seq #(
      .DATA_W(DATA_W), .DROP_W(DROP_W), .CNV_CYC(CNV_CYC), .RDL_CYC(RDL_CYC),
      .ACC_CYC(ACC_CYC), .FLT_CYC(FLT_CYC), .WAKE_CYC(CCLK_CYC), .TMO_CYC(TMO_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_req(sleep_req), .done_s(done_s),
      .bus_d(cvt_data), .cvt_start_n(cvt_start_n), .sel_n(sel_n), .rd_n(rd_n),
      .pwr_on(pwr_on), .samp_valid(samp_valid), .samp_data(samp_data),
      .tmo_err(tmo_err), .drop_count(drop_count));
endmodule

// File: tb/sim_adc_read_ctrl.sv
`timescale 1ns/1ps
module sim_adc_read_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [15:0] sample_period = 16'd2999;
   logic        sleep_req = 1'b0;
   logic        cvt_done = 1'b1;
   logic [11:0] cvt_data = 12'hA5A;
   logic        conv_clk, cvt_start_n, sel_n, rd_n, pwr_on, samp_valid, tmo_err;
   logic [11:0] samp_data;
   logic [15:0] drop_count;

   int checks = 0, fails = 0, cyc = 0;
   int resp_mode = 0;
   int ecnt = 0, ticks = 0;
   int real_starts = 0, valid_cnt = 0;
   logic [11:0] cur_code = 12'h0;
   bit dummy_conv = 0, dummy_seen = 0, wake_pend = 0, seen_low = 0;
   bit sel_in_window = 0, done_flag = 0;
   int wake_t = 0, rd_rise_t = -1000, rise_t = 0;
   int lowrun = 0, rl = 0, crun = 0, cruns = 0;
   int mphase = 0, mcnt = 0;
   logic p_start = 1, p_sel = 1, p_rd = 1, p_pwr = 1, p_valid = 0, p_cclk = 0;

   always #4 clk = ~clk;

   adc_read_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sample_period(sample_period),
      .sleep_req(sleep_req), .cvt_done(cvt_done), .cvt_data(cvt_data),
      .conv_clk(conv_clk), .cvt_start_n(cvt_start_n), .sel_n(sel_n), .rd_n(rd_n),
      .pwr_on(pwr_on), .samp_valid(samp_valid), .samp_data(samp_data),
      .tmo_err(tmo_err), .drop_count(drop_count));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                  tag, act, act, exp, exp, cyc);
      end
   endtask

   function automatic logic [11:0] code_of(input int n);
      if (n == 1) return 12'h000;
      if (n == 2) return 12'hFFF;
      if (n == 3) return 12'h800;
      if (n == 4) return 12'h7FF;
      return 12'((n * 937 + 21) % 4096);
   endfunction

   // sample request prediction from enabled cycles
   always @(posedge clk) begin
      if (rst_n && enable) begin
         if (ecnt == int'(sample_period)) begin
            ticks <= ticks + 1;
            ecnt  <= 0;
         end else ecnt <= ecnt + 1;
      end else ecnt <= 0;
   end

   // converter model and port monitor
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // R2 converter clock runs
         if (conv_clk != p_cclk) begin
            if (cruns > 0) chk(crun == 32, "R2 clock half width", crun, 32);
            cruns++;
            crun = 1;
         end else crun++;
         // start strobe
         if (!cvt_start_n && p_start) begin
            lowrun = 1;
            seen_low = 0;
            if (wake_pend) begin
               chk(cyc - wake_t >= 64, "R10 wake to start gap", cyc - wake_t, 64);
               wake_pend = 0;
               dummy_conv = 1;
               dummy_seen = 1;
            end else begin
               real_starts++;
               dummy_conv = 0;
            end
            cur_code = code_of(real_starts);
            chk(cyc - rd_rise_t >= 12, "R6 float gap before start", cyc - rd_rise_t, 12);
         end else if (!cvt_start_n) lowrun++;
         if (cvt_start_n && !p_start) begin
            chk(lowrun == 7, "R3 start strobe width", lowrun, 7);
            rise_t = cyc;
            done_flag = 1;
            if (resp_mode != 1) begin
               mphase = 1;
               mcnt = 0;
            end
         end
         // converter done line
         if (mphase == 1) begin
            mcnt++;
            if (mcnt == 10) begin
               cvt_done = 1'b0;
               seen_low = 1;
               mphase = (resp_mode == 2) ? 3 : 2;
               mcnt = 0;
            end
         end else if (mphase == 2) begin
            mcnt++;
            if (mcnt == 1700) begin
               cvt_done = 1'b1;
               mphase = 0;
            end
         end
         // select and read
         if (!sel_n && p_sel) begin
            sel_in_window = 1;
            chk(cvt_done && seen_low, "R4 select after done", int'(cvt_done), 1);
         end
         if (!rd_n && p_rd)
            chk(!p_sel, "R5 read after select", int'(p_sel), 0);
         if (!rd_n) rl++;
         if (rd_n && !p_rd) begin
            chk(rl == 14, "R5 read width", rl, 14);
            rd_rise_t = cyc;
         end
         if (rd_n) rl = 0;
         if (sel_n && !p_sel)
            chk(cyc == rd_rise_t + 1, "R6 select release", cyc - rd_rise_t, 1);
         // valid
         if (samp_valid) begin
            valid_cnt++;
            chk(!dummy_conv, "R10 wake data shown", 1, 0);
            chk(samp_data == cur_code, "R5 R7 captured data", samp_data, cur_code);
            chk(!p_valid, "R7 valid width", 2, 1);
         end
         // power
         if (!pwr_on)
            chk(rd_n && cvt_start_n, "R9 quiet while asleep", {rd_n, cvt_start_n}, 3);
         if (pwr_on && !p_pwr) begin
            wake_pend = 1;
            wake_t = cyc;
         end
         cvt_data = (!rd_n && rl >= 13) ? cur_code : 12'hA5A;
      end
      p_start = cvt_start_n; p_sel = sel_n; p_rd = rd_n; p_pwr = pwr_on;
      p_valid = samp_valid; p_cclk = conv_clk;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drop_inv(input string tag);
      chk(int'(drop_count) == ticks - real_starts, tag, drop_count, ticks - real_starts);
   endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   initial begin
      int rs;
      wait_cyc(5);
      // R1
      chk(cvt_start_n && sel_n && rd_n && pwr_on, "R1 strobes in reset",
          {cvt_start_n, sel_n, rd_n, pwr_on}, 15);
      chk(!samp_valid && !tmo_err, "R1 flags in reset", {samp_valid, tmo_err}, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk(drop_count == 0 && cvt_start_n && pwr_on, "R1 after reset", drop_count, 0);

      // R3 R5 R7 normal samples, no drops at long interval
      enable = 1'b1;
      while (valid_cnt < 8) @(negedge clk);
      chk(valid_cnt == real_starts, "R3 one sample per start", valid_cnt, real_starts);
      drop_inv("R8 no drops at long interval");

      // R12 sleep on the request cycle
      while (ecnt != int'(sample_period)) @(negedge clk);
      chk(cvt_start_n && sel_n, "R12 idle before collision", {cvt_start_n, sel_n}, 3);
      sleep_req = 1'b1;
      rs = real_starts;
      wait_cyc(1);
      chk(!pwr_on, "R12 sleep wins", pwr_on, 0);
      chk(real_starts == rs, "R12 no start", real_starts, rs);
      drop_inv("R12 colliding request dropped");
      wait_cyc(7000);
      chk(real_starts == rs, "R9 no starts asleep", real_starts, rs);
      drop_inv("R8 R9 drops while asleep");
      sleep_req = 1'b0;
      wait_cyc(2);
      chk(pwr_on, "R10 power back", pwr_on, 1);
      wait_cyc(2000);
      chk(dummy_seen, "R10 wake conversion ran", dummy_seen, 1);
      drop_inv("R8 after wake");

      // R8 short interval, requests collide with conversions
      enable = 1'b0;
      wait_cyc(3000);
      sample_period = 16'd999;
      enable = 1'b1;
      wait_cyc(12000);
      drop_inv("R8 short interval");
      chk(drop_count > 3, "R8 drops happened", drop_count, 4);

      // R11 timeout
      enable = 1'b0;
      wait_cyc(3000);
      resp_mode = 1;
      sample_period = 16'd9999;
      done_flag = 0;
      enable = 1'b1;
      while (!done_flag) @(negedge clk);
      sel_in_window = 0;
      wait_cyc(2500);
      chk(!tmo_err, "R11 not early", tmo_err, 0);
      wait_cyc(100);
      chk(tmo_err, "R11 flag set", tmo_err, 1);
      chk(!sel_in_window, "R11 no read cycle", sel_in_window, 0);
      wait_cyc(20);
      chk(tmo_err, "R11 sticky", tmo_err, 1);
      finish_up();
   end
endmodule